// File: doc/BRIEF.md
# Chained PWM Time-Base Synchronizer

This block holds six PWM time-base counters that share one clock and are aligned to each other through a chain of sync events. Each counter counts up from zero to its own period and wraps. When a sync event reaches a stage, the stage can replace its count with a preset phase value. Each stage also produces its own sync-out event, which becomes the sync-in of the next stage. By picking what each stage forwards, a system can stagger the counters by fixed phase offsets or restart them all together.

The chain has two segments. Stages 0 to 2 form the first segment, and its head is fed only by external pin A. Stages 3 to 5 form the second segment, and its head takes either the sync-out of stage 2 or external pin B, chosen by a one-bit select. The two pins are asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector before it can reach a counter, so every pin edge gives exactly one internal event with a fixed latency. The sync-outs of stage 0 and stage 3 are driven onto output pins.

All configuration arrives on plain input ports. No data stream crosses the block's boundary, so no port uses a valid/ready handshake. The configuration is assumed to change only while the block is in reset.

Top module: `pwm_sync_chain`

## Requirements
- R1: While `rst_n` is low, every stage count is 0.
- R2: When a stage does not load, its count increases by 1 on each clock. After it has been equal to (or above) its period, it returns to 0 on the next clock.
- R3: When a stage's sync-in is high and its phase enable is high on a clock edge, the count takes the stage's phase value at that edge. The load takes the place of the increment or wrap.
- R4: When a stage's phase enable is low, its sync-in does not change its count. A pass-through sync-out still forwards the event to the next stage.
- R5: Bits 5:4 of each stage's 8-bit control word select its sync-out. 00 forwards sync-in, 01 fires while the count is 0, 10 fires while the count equals compare-B, and 11 never fires.
- R6: Stages 1, 2, 4 and 5 take their sync-in from the previous stage's sync-out. Pass-through forwarding is combinational, so a whole segment loads on the same clock edge.
- R7: When `seg2_src_sel_i` is 1, stage 3 takes its sync-in from synchronized pin B. When it is 0, stage 3 takes it from stage 2's sync-out, and the other source has no effect.
- R8: Stage 0 takes its sync-in only from synchronized pin A.
- R9: Suppose a pin rises before clock edge E1 and stays high. The internal event is high for exactly one cycle, between E2 and E3, and the stage loads at E3. Holding the pin high does not cause a second load.
- R10: `sync_out_a_o` carries stage 0's sync-out and `sync_out_b_o` carries stage 3's sync-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_sync_a_i | input | 1 | Asynchronous sync pin feeding stage 0 |
| ext_sync_b_i | input | 1 | Asynchronous sync pin that can feed stage 3 |
| seg2_src_sel_i | input | 1 | Stage 3 source: 1 = pin B, 0 = stage 2 sync-out |
| ctl_word_i | input | 6*8 | Per-stage control word; bits 5:4 select sync-out |
| period_i | input | 6*16 | Per-stage period |
| phase_i | input | 6*16 | Per-stage phase value |
| cmpb_i | input | 6*16 | Per-stage compare-B value |
| phase_en_i | input | 6 | Per-stage phase-load enable |
| count_o | output | 6*16 | Per-stage time-base count |
| sync_out_a_o | output | 1 | Stage 0 sync-out |
| sync_out_b_o | output | 1 | Stage 3 sync-out |

## Verification
Each chain pattern starts from a common reset, so every counter that does not load reads a known free-running value. A stage that loaded shows its phase value, or its phase plus a known number of counts. The patterns cover full pass-through with both source selections, pin B while it is deselected, a disabled phase load in the middle of the chain, a stage with sync-out turned off, and zero-match and compare-B-match sources. Comparing all six counts shows where each event stopped and when it arrived. Directed runs then probe the synchronizer latency one cycle at a time, check that a held pin gives only one load, and check the period wrap and the output pins.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  // Width of each stage's control word; the sync-out select sits at bits 5:4.
  localparam int CTL_W  = 8;
  localparam int SO_LSB = 4;

  typedef enum logic [1:0] {
    SO_PASS = 2'b00,
    SO_ZERO = 2'b01,
    SO_CMPB = 2'b10,
    SO_OFF  = 2'b11
  } so_mode_e;

endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
  parameter int FLOPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pulse_o
);

  // FLOPS resolving flops plus one history flop for edge detection.
  logic [FLOPS:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[FLOPS-1:0], pin_i};
  end

  assign pulse_o = shreg[FLOPS-1] & ~shreg[FLOPS];

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmpb_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic             cmpb_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= phase_i;
    else if (cnt_q >= period_i) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);
  assign cmpb_o  = (cnt_q == cmpb_i);

endmodule

// File: rtl/pwm_sync_chain.sv
module pwm_sync_chain
  import pwm_sync_pkg::*;
#(
  parameter int NUM_STAGES = 6,
  parameter int CNT_W      = 16,
  parameter int SPLIT_IDX  = 3,
  parameter int SYNC_FLOPS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ext_sync_a_i,
  input  logic                          ext_sync_b_i,
  input  logic                          seg2_src_sel_i,
  input  logic [NUM_STAGES*CTL_W-1:0]   ctl_word_i,
  input  logic [NUM_STAGES*CNT_W-1:0]   period_i,
  input  logic [NUM_STAGES*CNT_W-1:0]   phase_i,
  input  logic [NUM_STAGES*CNT_W-1:0]   cmpb_i,
  input  logic [NUM_STAGES-1:0]         phase_en_i,
  output logic [NUM_STAGES*CNT_W-1:0]   count_o,
  output logic                          sync_out_a_o,
  output logic                          sync_out_b_o
);

  logic                  pulse_a;
  logic                  pulse_b;
  logic [NUM_STAGES-1:0] stage_zero;
  logic [NUM_STAGES-1:0] stage_cmpb;
  logic [NUM_STAGES-1:0] stage_sin;
  logic [NUM_STAGES-1:0] stage_sout;
  logic [NUM_STAGES-1:0] stage_load;

  // Resynchronize both asynchronous pins.
  pwm_edge_sync #(.FLOPS(SYNC_FLOPS)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_sync_a_i), .pulse_o(pulse_a)
  );
  pwm_edge_sync #(.FLOPS(SYNC_FLOPS)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_sync_b_i), .pulse_o(pulse_b)
  );

  // Chain resolution: walk the stages in order, carrying the upstream event.
  always_comb begin
    logic carry;
    logic sin_v;
    logic sout_v;
    carry      = 1'b0;
    stage_sin  = '0;
    stage_sout = '0;
    for (int i = 0; i < NUM_STAGES; i++) begin
      if (i == 0)                               sin_v = pulse_a;
      else if (i == SPLIT_IDX && seg2_src_sel_i) sin_v = pulse_b;
      else                                      sin_v = carry;
      case (so_mode_e'(ctl_word_i[i*CTL_W+SO_LSB +: 2]))
        SO_PASS: sout_v = sin_v;
        SO_ZERO: sout_v = stage_zero[i];
        SO_CMPB: sout_v = stage_cmpb[i];
        default: sout_v = 1'b0;
      endcase
      stage_sin[i]  = sin_v;
      stage_sout[i] = sout_v;
      carry         = sout_v;
    end
  end

  assign stage_load = stage_sin & phase_en_i;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (stage_load[g]),
      .phase_i (phase_i [g*CNT_W +: CNT_W]),
      .period_i(period_i[g*CNT_W +: CNT_W]),
      .cmpb_i  (cmpb_i  [g*CNT_W +: CNT_W]),
      .count_o (count_o [g*CNT_W +: CNT_W]),
      .zero_o  (stage_zero[g]),
      .cmpb_o  (stage_cmpb[g])
    );
  end

  assign sync_out_a_o = stage_sout[0];
  assign sync_out_b_o = stage_sout[SPLIT_IDX];

endmodule

// File: rtl/pwm_sync_chain_chk.sv
module pwm_sync_chain_chk
  import pwm_sync_pkg::*;
#(
  parameter int NUM_STAGES = 6,
  parameter int CNT_W      = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        pulse_a,
  input logic                        pulse_b,
  input logic [NUM_STAGES*CTL_W-1:0] ctl_word_i,
  input logic [NUM_STAGES*CNT_W-1:0] period_i,
  input logic [NUM_STAGES*CNT_W-1:0] phase_i,
  input logic [NUM_STAGES-1:0]       phase_en_i,
  input logic [NUM_STAGES*CNT_W-1:0] count_o,
  input logic [NUM_STAGES-1:0]       stage_sin,
  input logic [NUM_STAGES-1:0]       stage_sout
);

  // R9: a synchronized pin event lasts exactly one cycle.
  p_single_pulse_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_a |=> !pulse_a);
  p_single_pulse_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_b |=> !pulse_b);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_chk
    // R3: an enabled sync-in loads the phase value.
    p_phase_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_sin[g] && phase_en_i[g]) |=>
        (count_o[g*CNT_W +: CNT_W] == $past(phase_i[g*CNT_W +: CNT_W])));
    // R2: count reaching its period returns to zero.
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(stage_sin[g] && phase_en_i[g]) &&
       count_o[g*CNT_W +: CNT_W] >= period_i[g*CNT_W +: CNT_W]) |=>
        (count_o[g*CNT_W +: CNT_W] == '0));
    // R2: below the period the count steps by one.
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(stage_sin[g] && phase_en_i[g]) &&
       count_o[g*CNT_W +: CNT_W] < period_i[g*CNT_W +: CNT_W]) |=>
        (count_o[g*CNT_W +: CNT_W] == $past(count_o[g*CNT_W +: CNT_W]) + 1'b1));
    // R5: select 11 keeps the sync-out quiet.
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_word_i[g*CTL_W+SO_LSB +: 2] == 2'b11) |-> !stage_sout[g]);
  end

endmodule

bind pwm_sync_chain pwm_sync_chain_chk #(
  .NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_a(pulse_a), .pulse_b(pulse_b),
  .ctl_word_i(ctl_word_i), .period_i(period_i), .phase_i(phase_i),
  .phase_en_i(phase_en_i), .count_o(count_o),
  .stage_sin(stage_sin), .stage_sout(stage_sout)
);

// File: tb/pwm_sync_chain_bench.sv
module pwm_sync_chain_bench;

  localparam int N  = 6;
  localparam int CW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pin_a = 1'b0;
  logic            pin_b = 1'b0;
  logic            sel = 1'b0;
  logic [N*8-1:0]  ctl = '0;
  logic [N*CW-1:0] period = '0;
  logic [N*CW-1:0] phase = '0;
  logic [N*CW-1:0] cmpb = '0;
  logic [N-1:0]    en = '1;
  logic [N*CW-1:0] count;
  logic            so_a;
  logic            so_b;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pwm_sync_chain u_pwm_sync_chain (
    .clk(clk), .rst_n(rst_n), .ext_sync_a_i(pin_a), .ext_sync_b_i(pin_b),
    .seg2_src_sel_i(sel), .ctl_word_i(ctl), .period_i(period),
    .phase_i(phase), .cmpb_i(cmpb), .phase_en_i(en), .count_o(count),
    .sync_out_a_o(so_a), .sync_out_b_o(so_b)
  );

  typedef struct packed {
    logic                pa;
    logic                pb;
    logic                sl;
    logic [11:0]         so;   // stage 5 in the top two bits
    logic [5:0]          en;
    logic [5:0][15:0]    ex;   // index 5 first in the literal
  } vec_t;

  // Expected counts are sampled after the fifth clock following reset release;
  // an unloaded stage therefore reads 5.
  localparam vec_t VECS [0:8] = '{
    // R6 R8: full pass-through, pin A reloads the whole chain at once
    '{1'b1, 1'b0, 1'b0, 12'h000, 6'h3f, {16'd600,16'd500,16'd400,16'd300,16'd200,16'd100}},
    // R7: stage 3 on pin B, pin A reaches only the first segment
    '{1'b1, 1'b0, 1'b1, 12'h000, 6'h3f, {16'd5,16'd5,16'd5,16'd300,16'd200,16'd100}},
    // R7: pin B selected and pulsed
    '{1'b0, 1'b1, 1'b1, 12'h000, 6'h3f, {16'd600,16'd500,16'd400,16'd5,16'd5,16'd5}},
    // R7: pin B deselected has no effect
    '{1'b0, 1'b1, 1'b0, 12'h000, 6'h3f, {16'd5,16'd5,16'd5,16'd5,16'd5,16'd5}},
    // R4: stage 1 disabled but still forwards
    '{1'b1, 1'b0, 1'b0, 12'h000, 6'b111101, {16'd600,16'd500,16'd400,16'd300,16'd5,16'd100}},
    // R5: stage 2 select 11 blocks the chain
    '{1'b1, 1'b0, 1'b0, 12'h030, 6'h3f, {16'd5,16'd5,16'd5,16'd300,16'd200,16'd100}},
    // R5: stage 0 select 01 fires while its count is 0 (before first edge)
    '{1'b0, 1'b0, 1'b0, 12'h001, 6'h3f, {16'd604,16'd504,16'd404,16'd304,16'd204,16'd5}},
    // R5: stage 0 select 10 fires at count 3 (compare-B = 3)
    '{1'b0, 1'b0, 1'b0, 12'h002, 6'h3f, {16'd601,16'd501,16'd401,16'd301,16'd201,16'd5}},
    // R5 R6: stage 1 select 01 loads downstream at first edge
    '{1'b1, 1'b0, 1'b0, 12'h004, 6'h3f, {16'd604,16'd504,16'd404,16'd304,16'd200,16'd100}}
  };

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [11:0] so, input logic [5:0] e, input logic s);
    rst_n = 1'b0;
    pin_a = 1'b0;
    pin_b = 1'b0;
    sel   = s;
    en    = e;
    for (int i = 0; i < N; i++) begin
      ctl[i*8 +: 8]    = {2'b00, so[i*2 +: 2], 4'b0000};
      period[i*CW +: CW] = 16'd1000;
      phase[i*CW +: CW]  = 16'(100 * (i + 1));
      cmpb[i*CW +: CW]   = 16'd3;
    end
    step(2);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    setup(12'h000, 6'h3f, 1'b0);
    for (int i = 0; i < N; i++) check("R1 reset count", count[i*CW +: CW], 16'd0);

    // Vector table walk
    for (int v = 0; v < 9; v++) begin
      setup(VECS[v].so, VECS[v].en, VECS[v].sl);
      rst_n = 1'b1;
      step(2);
      pin_a = VECS[v].pa;
      pin_b = VECS[v].pb;
      step(3);
      for (int i = 0; i < N; i++)
        check($sformatf("R3 R6 vector %0d stage %0d", v, i), count[i*CW +: CW], VECS[v].ex[i]);
    end

    // R9 R10: synchronizer latency and single load on a held pin
    setup(12'h000, 6'h3f, 1'b0);
    rst_n = 1'b1;
    step(2);
    pin_a = 1'b1;
    step(1);
    check("R9 no load after first edge", count[CW-1:0], 16'd3);
    check("R10 sync_out_a idle", {15'd0, so_a}, 16'd0);
    step(1);
    check("R9 no load after second edge", count[CW-1:0], 16'd4);
    check("R10 sync_out_a pulse", {15'd0, so_a}, 16'd1);
    step(1);
    check("R9 load on third edge", count[CW-1:0], 16'd100);
    step(1);
    check("R9 held pin no reload", count[CW-1:0], 16'd101);
    check("R9 pulse single cycle", {15'd0, so_a}, 16'd0);

    // R2 R10: wrap at period 4, stage 3 zero-match on its pin
    setup(12'h040, 6'h3f, 1'b0);
    period[CW-1:0]        = 16'd4;
    period[3*CW +: CW]    = 16'd4;
    rst_n = 1'b1;
    step(4);
    check("R2 count at period", count[CW-1:0], 16'd4);
    check("R10 sync_out_b low off zero", {15'd0, so_b}, 16'd0);
    step(1);
    check("R2 wrap to zero", count[CW-1:0], 16'd0);
    check("R10 sync_out_b at zero", {15'd0, so_b}, 16'd1);
    step(1);
    check("R2 restart after wrap", count[CW-1:0], 16'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule